// File: doc/BRIEF.md
# Destination-Interleaved Edge Crossbar

This block sits between the source half and the destination half of a multi-stream graph-processing pipeline. Each of the N source lanes offers one edge update per cycle. An update carries a destination vertex ID and a computed value. The crossbar sends every update to the destination lane that owns its vertex. Ownership is given by the low bits of the vertex ID, so each destination lane only ever sees vertices from its own private slice of the temporary-property scratchpad. Source vertices are spread across the source lanes in the same modulo fashion upstream, so any source lane may hold an update for any destination lane.

When several source lanes aim at the same destination lane in one cycle, a round-robin arbiter for that lane picks one winner. The losing lanes see their ready held low and must keep their update unchanged. Updates aimed at different destination lanes move in parallel, so up to N updates pass per cycle. Every lane on both sides uses a valid/ready handshake. A transfer happens on a rising clock edge where both valid and ready are high.

The lane count N is a power of two (2, 4 or 8). Selecting the lane is a plain bit slice, so no divider is needed.

Top module: `dix_edge_xbar`

## Requirements
- R1: An update whose destination ID has low log2(N) bits equal to j appears only on destination lane j, with its ID and value unchanged.
- R2: Every update accepted from a source lane is delivered exactly once: none is lost and none is duplicated.
- R3: Updates that travel from one source lane to one destination lane leave in the same order in which they were accepted.
- R4: Each destination lane has a round-robin pointer, which is 0 after reset. Priority runs from the pointer upward, wrapping modulo N. After a transfer from source lane k, the pointer becomes (k+1) mod N.
- R5: While a destination lane shows valid with ready low, it keeps valid, ID and value stable. It keeps the same chosen source lane even if a higher-priority request arrives, and no source lane aimed at it sees ready.
- R6: At most one source lane is accepted per destination lane per cycle. A source lane sees ready only when it is valid, it has won, and its destination lane is ready.
- R7: After reset, with no source lane valid, all destination valids and all source readies are low.
- R8: Source lanes aimed at N distinct destination lanes, with every destination ready, all transfer in the same cycle.
- R9: A source lane with valid low is ignored. It never sees ready, and its ID and value never appear on any destination lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_valid | input | N | Per source lane: an update is offered |
| src_dst | input | N*ID_W | Per source lane: destination vertex ID (lane i at bits i*ID_W) |
| src_val | input | N*VAL_W | Per source lane: update value |
| src_ready | output | N | Per source lane: the update is taken on this edge |
| dst_valid | output | N | Per destination lane: an update is presented |
| dst_id | output | N*ID_W | Per destination lane: vertex ID of the presented update |
| dst_val | output | N*VAL_W | Per destination lane: value of the presented update |
| dst_ready | input | N | Per destination lane: the consumer accepts the update |

## Verification
The hardest case is a destination lane that is stalled while a new request appears that the round-robin order ranks above the request already presented. If the grant were re-evaluated at that point, the presented data would change under a stall. The stimulus builds this case directly. It points two source lanes at one stalled lane, then adds a third source lane that sits just at the pointer. It checks that the presented value does not change, and that the three transfers after release follow the predicted pointer order. A long random phase adds random vertex IDs, source gaps and destination back-pressure. A scoreboard, kept per source and destination pair, checks order and exactly-once delivery.

// File: rtl/dix_pkg.sv
package dix_pkg;

  // Arbiter mode: free to pick, or holding the grant of a stalled lane
  typedef enum logic {
    ARB_FREE = 1'b0,
    ARB_HELD = 1'b1
  } arb_mode_e;

endpackage

// File: rtl/dix_route.sv
// Per source lane: turns the lane field of the destination ID into a one-hot request.
module dix_route #(
  parameter  int N  = 4,
  localparam int IW = $clog2(N)
) (
  input  logic          valid,
  input  logic [IW-1:0] lane,
  output logic [N-1:0]  req
);

  always_comb begin
    for (int j = 0; j < N; j++) begin
      req[j] = valid && (lane == IW'(j));
    end
  end

endmodule

// File: rtl/dix_rr_arb.sv
// Per destination lane: round-robin arbiter with a grant lock during stalls.
module dix_rr_arb
  import dix_pkg::*;
#(
  parameter  int N  = 4,
  localparam int IW = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         take,
  input  logic         stall,
  output logic [N-1:0] gnt
);

  logic [IW-1:0] ptr_q, ptr_d;
  logic          ptr_en;
  arb_mode_e     mode_q, mode_d;
  logic [N-1:0]  held_q, held_d;
  logic          held_en;
  logic [N-1:0]  pick;
  logic [IW-1:0] win_idx;

  // Scan from the pointer upward; the lane field wraps naturally
  always_comb begin : scan_c
    logic          found;
    logic [IW-1:0] idx;
    pick  = '0;
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < N; k++) begin
      idx = ptr_q + IW'(k);
      if (!found && req[idx]) begin
        pick[idx] = 1'b1;
        found     = 1'b1;
      end
    end
  end

  assign gnt = (mode_q == ARB_HELD) ? (held_q & req) : pick;

  always_comb begin
    win_idx = '0;
    for (int k = 0; k < N; k++) begin
      if (gnt[k]) win_idx = IW'(k);
    end
  end

  // Next state
  always_comb begin
    ptr_en  = take;
    ptr_d   = win_idx + IW'(1);
    held_en = stall;
    held_d  = gnt;
    mode_d  = stall ? ARB_HELD : ARB_FREE;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      held_q <= '0;
      mode_q <= ARB_FREE;
    end else begin
      mode_q <= mode_d;
      if (ptr_en)  ptr_q  <= ptr_d;
      if (held_en) held_q <= held_d;
    end
  end

  assert_gnt_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  assert_gnt_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

  assert_ptr_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (ptr_q == IW'($past(win_idx) + IW'(1))));

endmodule

// File: rtl/dix_edge_xbar.sv
// Top: N x N crossbar that steers edge updates by destination lane.
module dix_edge_xbar #(
  parameter  int N     = 4,
  parameter  int ID_W  = 16,
  parameter  int VAL_W = 32,
  localparam int IW    = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       src_valid,
  input  logic [N*ID_W-1:0]  src_dst,
  input  logic [N*VAL_W-1:0] src_val,
  output logic [N-1:0]       src_ready,
  output logic [N-1:0]       dst_valid,
  output logic [N*ID_W-1:0]  dst_id,
  output logic [N*VAL_W-1:0] dst_val,
  input  logic [N-1:0]       dst_ready
);

  logic [N-1:0]     req_row [N];  // by source: which destination it wants
  logic [N-1:0]     req_col [N];  // by destination: which sources want it
  logic [N-1:0]     gnt_col [N];  // by destination: which source won
  logic [N-1:0]     take;
  logic [N-1:0]     stall;
  logic [ID_W-1:0]  mux_id  [N];
  logic [VAL_W-1:0] mux_val [N];

  // Request decode, one per source lane
  for (genvar i = 0; i < N; i++) begin : g_src
    dix_route #(.N(N)) route_i (
      .valid (src_valid[i]),
      .lane  (src_dst[i*ID_W +: IW]),
      .req   (req_row[i])
    );
  end

  always_comb begin
    for (int j = 0; j < N; j++) begin
      for (int i = 0; i < N; i++) begin
        req_col[j][i] = req_row[i][j];
      end
    end
  end

  // Arbiter and output mux, one per destination lane
  for (genvar j = 0; j < N; j++) begin : g_dst
    dix_rr_arb #(.N(N)) arb_i (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req_col[j]),
      .take  (take[j]),
      .stall (stall[j]),
      .gnt   (gnt_col[j])
    );

    always_comb begin
      mux_id[j]  = '0;
      mux_val[j] = '0;
      for (int i = 0; i < N; i++) begin
        if (gnt_col[j][i]) begin
          mux_id[j]  = mux_id[j]  | src_dst[i*ID_W +: ID_W];
          mux_val[j] = mux_val[j] | src_val[i*VAL_W +: VAL_W];
        end
      end
    end

    assign dst_valid[j]               = |gnt_col[j];
    assign dst_id[j*ID_W +: ID_W]     = mux_id[j];
    assign dst_val[j*VAL_W +: VAL_W]  = mux_val[j];
    assign take[j]                    = dst_valid[j] & dst_ready[j];
    assign stall[j]                   = dst_valid[j] & ~dst_ready[j];

    assert_lane_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
      dst_valid[j] |-> (dst_id[j*ID_W +: IW] == IW'(j)));

    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_valid[j] && !dst_ready[j]) |=>
        (dst_valid[j] && $stable(dst_id[j*ID_W +: ID_W])
                      && $stable(dst_val[j*VAL_W +: VAL_W])));
  end

  // Source ready: won and the destination is ready
  always_comb begin
    for (int i = 0; i < N; i++) begin
      src_ready[i] = 1'b0;
      for (int j = 0; j < N; j++) begin
        src_ready[i] = src_ready[i] | (gnt_col[j][i] & dst_ready[j]);
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_ready_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      src_ready[i] |-> (src_valid[i] && dst_ready[src_dst[i*ID_W +: IW]]));
  end

endmodule

// File: tb/dix_edge_xbar_tb_top.sv
module dix_edge_xbar_tb_top;
  localparam int N   = 4;
  localparam int IDW = 16;
  localparam int VW  = 32;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [N-1:0]     src_valid;
  logic [N*IDW-1:0] src_dst;
  logic [N*VW-1:0]  src_val;
  logic [N-1:0]     src_ready;
  logic [N-1:0]     dst_valid;
  logic [N*IDW-1:0] dst_id;
  logic [N*VW-1:0]  dst_val;
  logic [N-1:0]     dst_ready;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [IDW+VW-1:0] srcq [N][$];
  logic [IDW+VW-1:0] expq [N][N][$];

  always #2 clk = ~clk;

  dix_edge_xbar #(.N(N), .ID_W(IDW), .VAL_W(VW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .src_valid(src_valid), .src_dst(src_dst), .src_val(src_val), .src_ready(src_ready),
    .dst_valid(dst_valid), .dst_id(dst_id), .dst_val(dst_val), .dst_ready(dst_ready)
  );

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(int i, bit v, logic [IDW-1:0] id, logic [VW-1:0] val);
    src_valid[i]           = v;
    src_dst[i*IDW +: IDW]  = id;
    src_val[i*VW +: VW]    = val;
  endtask

  task automatic idle_all();
    for (int i = 0; i < N; i++) drive(i, 1'b0, '0, '0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  function automatic logic [VW-1:0] oval(int j);
    return dst_val[j*VW +: VW];
  endfunction

  // Scoreboard driver side: queue the stimulus and the expected delivery
  task automatic push(int i, logic [IDW-1:0] id, logic [VW-1:0] val);
    srcq[i].push_back({id, val});
    expq[id[1:0]][i].push_back({id, val});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] held;
    rst_n = 1'b0;
    idle_all();
    dst_ready = '1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R7: quiet after reset
    @(negedge clk);
    check(dst_valid == '0, "R7", "dst_valid", dst_valid, 0);
    check(src_ready == '0, "R7", "src_ready", src_ready, 0);

    // R8 / R1: permutation, source i -> lane (i+1)%4
    @(posedge clk); #1;
    for (int i = 0; i < N; i++)
      drive(i, 1'b1, IDW'(16'h0100 * i + (i + 1) % N), {8'(i), 8'hB0, 16'(i)});
    @(negedge clk);
    check(src_ready == 4'hF, "R8", "all ready", src_ready, 4'hF);
    check(dst_valid == 4'hF, "R8", "all valid", dst_valid, 4'hF);
    for (int j = 0; j < N; j++) begin
      check(oval(j) == {8'((j + 3) % N), 8'hB0, 16'((j + 3) % N)}, "R1", "lane value",
            oval(j), {8'((j + 3) % N), 8'hB0, 16'((j + 3) % N)});
      check(dst_id[j*IDW +: IDW] == IDW'(16'h0100 * ((j + 3) % N) + j), "R1", "lane id",
            dst_id[j*IDW +: IDW], IDW'(16'h0100 * ((j + 3) % N) + j));
    end
    @(posedge clk); #1 idle_all();
    // pointer of lane j is now j

    // R4: all sources fight for lane 2 (pointer 2): winners 2,3,0,1,...
    for (int i = 0; i < N; i++)
      drive(i, 1'b1, IDW'(16'h0C00 | (i << 4) | 2), {8'(i), 8'hC0, 16'h0});
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check(src_ready == N'(1 << ((2 + k) % N)), "R4", "rr winner", src_ready, 1 << ((2 + k) % N));
      check(oval(2)[31:24] == 8'((2 + k) % N), "R4", "rr source", oval(2)[31:24], (2 + k) % N);
      @(posedge clk); #1;
    end
    idle_all();

    // R5 / R9: lane 1 stalled (pointer 1); sources 0 and 3 request, source 2 idle
    dst_ready = 4'b1101;
    drive(0, 1'b1, 16'h0011, {8'd0, 8'hD0, 16'h0});
    drive(3, 1'b1, 16'h0031, {8'd3, 8'hD0, 16'h0});
    drive(2, 1'b0, 16'h0021, 32'hDEAD_BEEF);
    @(negedge clk);
    check(src_ready == '0, "R5", "no ready while stalled", src_ready, 0);
    check(dst_valid[1] == 1'b1, "R5", "valid while stalled", dst_valid[1], 1);
    check(oval(1)[31:24] == 8'd3, "R4", "stall pick", oval(1)[31:24], 3);
    held = oval(1);
    @(posedge clk); #1;
    drive(1, 1'b1, 16'h0015, {8'd1, 8'hD0, 16'h0});  // ranks first at pointer 1
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      check(oval(1) == held, "R5", "held value", oval(1), held);
      check(src_ready == '0, "R5", "ready low", src_ready, 0);
      check(oval(1) != 32'hDEAD_BEEF, "R9", "idle data absent", oval(1), held);
      @(posedge clk); #1;
    end
    dst_ready = '1;
    @(negedge clk);
    check(src_ready == 4'b1000, "R5", "held winner goes", src_ready, 4'b1000);
    @(posedge clk); #1 drive(3, 1'b0, '0, '0);
    @(negedge clk);
    check(src_ready == 4'b0001, "R4", "after 3 comes 0", src_ready, 4'b0001);
    @(posedge clk); #1 drive(0, 1'b0, '0, '0);
    @(negedge clk);
    check(src_ready == 4'b0010, "R4", "then 1", src_ready, 4'b0010);
    check(src_ready[2] == 1'b0, "R9", "idle source not ready", src_ready[2], 0);
    @(posedge clk); #1 idle_all();

    // R2 / R3: random stress through the scoreboard
    for (int i = 0; i < N; i++)
      for (int k = 0; k < 40; k++)
        push(i, IDW'($urandom), {8'(i), 8'hE0, 16'(k)});
    begin
      logic [N-1:0] hold = '0;
      logic [N-1:0] fire = '0;
      bit busy = 1'b1;
      while (busy) begin
        @(posedge clk); #1;
        for (int i = 0; i < N; i++) begin
          if (fire[i]) begin
            void'(srcq[i].pop_front());
            hold[i] = 1'b0;
          end
          if (!hold[i]) begin
            if (srcq[i].size() > 0 && ($urandom % 4) != 0) begin
              drive(i, 1'b1, srcq[i][0][IDW+VW-1:VW], srcq[i][0][VW-1:0]);
              hold[i] = 1'b1;
            end else begin
              drive(i, 1'b0, '0, '0);
            end
          end
        end
        dst_ready = N'($urandom);
        @(negedge clk);
        for (int j = 0; j < N; j++) begin
          if (dst_valid[j] && dst_ready[j]) begin
            logic [IDW+VW-1:0] got;
            int s;
            got = {dst_id[j*IDW +: IDW], oval(j)};
            s = int'(oval(j)[31:24]);
            check(dst_id[j*IDW +: 2] == 2'(j), "R1", "stress lane", dst_id[j*IDW +: 2], j);
            if (s >= N || expq[j][s].size() == 0) begin
              check(1'b0, "R2", "unexpected delivery", got, 0);
            end else begin
              logic [IDW+VW-1:0] exp;
              exp = expq[j][s].pop_front();
              check(got == exp, "R3", "order", got, exp);
            end
          end
        end
        fire = src_valid & src_ready;
        busy = 1'b0;
        for (int i = 0; i < N; i++)
          if (srcq[i].size() > 0) busy = 1'b1;
      end
    end
    idle_all();
    for (int j = 0; j < N; j++)
      for (int i = 0; i < N; i++)
        check(expq[j][i].size() == 0, "R2", "undelivered", expq[j][i].size(), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule